// File: doc/BRIEF.md
# Boundary-Scan Dual Nine-Bit Latch

This block holds two independent nine-bit bytes, A and B, in level-sensitive latches. Each byte has an active-high latch enable and an active-low output enable. While a byte's latch enable is high, its outputs follow its data inputs. When the enable falls, the last value is held. A high output enable turns that byte's drivers off. The three-state pins are modelled as a data bus plus a one-bit drive enable per byte. The pin drivers themselves sit outside the block.

Around the datapath sits a four-wire test access port (TCK, TMS, TDI, TDO). It drives a sixteen-state controller, a three-bit instruction register, a one-bit bypass stage and a 42-cell boundary register that covers every data and control pin. Board test software uses it for five tasks:

- sampling the pins without disturbing them,
- preloading output values,
- driving the outputs from the scan chain,
- clamping the outputs while keeping a short scan path,
- turning every output off.

There is no dedicated test reset pin; holding TMS high returns the port to its reset state.

Top module: `bsl_top`

## Requirements
- R1: With instruction BYPASS, SAMPLE or any unused code active, and a byte's output enable low and its latch enable high, that byte's drive enable is 1 and its data outputs equal its data inputs. The two bytes act independently.
- R2: While a byte's latch enable is low, its data outputs keep the value present when the enable fell, whatever the data inputs and output enable do.
- R3: While a byte's output enable is high in normal operation, its drive enable is 0, independent of latch enable and data. The other byte is unaffected.
- R4: The test controller is the standard sixteen-state machine clocked on the rising TCK edge. Five TCK cycles with TMS high reach Test-Logic-Reset from any state, which makes BYPASS the active instruction and returns the pins to normal operation.
- R5: The instruction register is 3 bits, shifted LSB first, and loads 001 in Capture-IR. Codes are EXTEST 000, SAMPLE 001, CLAMP 010, HIGHZ 011 and BYPASS 111. Every other code acts as BYPASS. A new instruction takes effect in Update-IR.
- R6: Under BYPASS the data path is one stage that loads 0 in Capture-DR. Bits shifted out are bits shifted in, delayed by one, with a leading 0.
- R7: The boundary register is 42 cells, shifted out on TDO from cell 0 with TDI entering cell 41. Cells 8..0 hold the A data inputs and cells 17..9 the B data inputs. Cells 18/19 hold the A/B latch enables and cells 20/21 the A/B output enables. Cells 30..22 hold the A outputs and cells 39..31 the B outputs. Cells 40/41 hold the A/B drive enables, where 1 means driving. Capture-DR loads every cell from its pin.
- R8: SAMPLE (preload) captures and shifts the boundary register without changing the output pins.
- R9: Under EXTEST the output data and drive enables come from the boundary update stage, which loads on the falling TCK edge in Update-DR. The latch inputs no longer reach the pins.
- R10: Under CLAMP the outputs and drive enables come from the boundary update stage, and the bypass stage sits between TDI and TDO.
- R11: Under HIGHZ both drive enables are 0 and the bypass stage sits between TDI and TDO.
- R12: TDO changes on the falling TCK edge, and its enable is 1 only while the controller is in Shift-IR or Shift-DR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| tms | input | 1 | Test mode select, sampled on rising TCK |
| tdi | input | 1 | Serial test data in |
| tdo | output | 1 | Serial test data out, updated on falling TCK |
| tdo_en | output | 1 | TDO drive enable |
| a_din | input | 9 | Byte A data inputs |
| b_din | input | 9 | Byte B data inputs |
| a_le | input | 1 | Byte A latch enable, high = transparent |
| b_le | input | 1 | Byte B latch enable, high = transparent |
| a_oe_n | input | 1 | Byte A output enable, active low |
| b_oe_n | input | 1 | Byte B output enable, active low |
| a_dout | output | 9 | Byte A output data |
| a_dout_en | output | 1 | Byte A drive enable, 1 = driving |
| b_dout | output | 9 | Byte B output data |
| b_dout_en | output | 1 | Byte B drive enable, 1 = driving |

## Verification
The latch checks are sampled on rising TCK, although the datapath has no clock. They assume that the data, latch enable and output enable pins change at most once per TCK period and never close to a rising edge, so a pulse on a latch enable cannot fall between two samples. The port checks also assume that TMS and TDI are stable across each rising edge. The stimulus changes every input a short time after a falling TCK edge and then waits at least one full period, which keeps within both assumptions.

// File: rtl/bsl_pkg.sv
`timescale 1ns/1ps
package bsl_pkg;
   localparam int IR_W = 3;

   typedef enum logic [3:0] {
      TLR, RTI, SEL_DR, CAP_DR, SH_DR, EX1_DR, PA_DR, EX2_DR, UPD_DR,
      SEL_IR, CAP_IR, SH_IR, EX1_IR, PA_IR, EX2_IR, UPD_IR
   } tap_state_t;

   localparam logic [IR_W-1:0] OP_EXTEST  = 3'b000;
   localparam logic [IR_W-1:0] OP_SAMPLE  = 3'b001;
   localparam logic [IR_W-1:0] OP_CLAMP   = 3'b010;
   localparam logic [IR_W-1:0] OP_HIGHZ   = 3'b011;
   localparam logic [IR_W-1:0] OP_BYPASS  = 3'b111;
   localparam logic [IR_W-1:0] IR_CAPTURE = 3'b001;

   typedef enum logic [2:0] {
      I_BYPASS, I_SAMPLE, I_EXTEST, I_CLAMP, I_HIGHZ
   } instr_t;
endpackage

// File: rtl/bsl_tap.sv
`timescale 1ns/1ps
module bsl_tap
   import bsl_pkg::*;
(
   input  logic       tck,
   input  logic       tms,
   output tap_state_t state,
   output logic       primed
);
   tap_state_t state_q = TLR;
   tap_state_t state_d;
   logic       primed_q = 1'b0;
   logic [2:0] hi_cnt_q = 3'd0;

   always_comb begin
      case (state_q)
         TLR:     state_d = tms ? TLR    : RTI;
         RTI:     state_d = tms ? SEL_DR : RTI;
         SEL_DR:  state_d = tms ? SEL_IR : CAP_DR;
         CAP_DR:  state_d = tms ? EX1_DR : SH_DR;
         SH_DR:   state_d = tms ? EX1_DR : SH_DR;
         EX1_DR:  state_d = tms ? UPD_DR : PA_DR;
         PA_DR:   state_d = tms ? EX2_DR : PA_DR;
         EX2_DR:  state_d = tms ? UPD_DR : SH_DR;
         UPD_DR:  state_d = tms ? SEL_DR : RTI;
         SEL_IR:  state_d = tms ? TLR    : CAP_IR;
         CAP_IR:  state_d = tms ? EX1_IR : SH_IR;
         SH_IR:   state_d = tms ? EX1_IR : SH_IR;
         EX1_IR:  state_d = tms ? UPD_IR : PA_IR;
         PA_IR:   state_d = tms ? EX2_IR : PA_IR;
         EX2_IR:  state_d = tms ? UPD_IR : SH_IR;
         UPD_IR:  state_d = tms ? SEL_DR : RTI;
         default: state_d = TLR;
      endcase
   end

   always_ff @(posedge tck) begin
      state_q  <= state_d;
      primed_q <= 1'b1;
      hi_cnt_q <= !tms ? 3'd0 : (hi_cnt_q == 3'd5 ? 3'd5 : hi_cnt_q + 3'd1);
   end

   assign state  = state_q;
   assign primed = primed_q;

   // R4: five rising edges with TMS high always land in Test-Logic-Reset
   p_tms_reset_r4: assert property (@(posedge tck) disable iff (!primed_q)
      (hi_cnt_q == 3'd5) |-> (state_q == TLR));
endmodule

// File: rtl/bsl_ir.sv
`timescale 1ns/1ps
module bsl_ir
   import bsl_pkg::*;
(
   input  logic       tck,
   input  logic       tdi,
   input  logic       primed,
   input  tap_state_t state,
   output logic       ir_tdo,
   output instr_t     instr
);
   logic [IR_W-1:0] sr_q = '0;
   logic [IR_W-1:0] ir_q = OP_BYPASS;

   always_ff @(posedge tck) begin
      if (state == CAP_IR)     sr_q <= IR_CAPTURE;
      else if (state == SH_IR) sr_q <= {tdi, sr_q[IR_W-1:1]};
   end

   always_ff @(negedge tck) begin
      if (state == TLR)         ir_q <= OP_BYPASS;
      else if (state == UPD_IR) ir_q <= sr_q;
   end

   always_comb begin
      case (ir_q)
         OP_EXTEST: instr = I_EXTEST;
         OP_SAMPLE: instr = I_SAMPLE;
         OP_CLAMP:  instr = I_CLAMP;
         OP_HIGHZ:  instr = I_HIGHZ;
         default:   instr = I_BYPASS;
      endcase
   end

   assign ir_tdo = sr_q[0];

   // R5: Capture-IR leaves the fixed pattern in the shift stage
   p_ir_capture_r5: assert property (@(posedge tck) disable iff (!primed)
      (state == CAP_IR) |=> (sr_q == IR_CAPTURE));
endmodule

// File: rtl/bsl_bsr.sv
`timescale 1ns/1ps
module bsl_bsr
   import bsl_pkg::*;
#(
   parameter int LEN    = 42,
   parameter int UPD_LO = 22
) (
   input  logic              tck,
   input  logic              tdi,
   input  logic              primed,
   input  tap_state_t        state,
   input  logic              sel,
   input  logic [LEN-1:0]    cap_vec,
   output logic              bsr_tdo,
   output logic [LEN-1:UPD_LO] upd
);
   generate
      if (LEN < 2 || UPD_LO < 0 || UPD_LO >= LEN) begin : g_bad_len
         $error("bsl_bsr: LEN and UPD_LO out of range");
      end
   endgenerate

   logic [LEN-1:0]      sr_q  = '0;
   logic [LEN-1:UPD_LO] upd_q = '0;

   always_ff @(posedge tck) begin
      if (sel && state == CAP_DR)     sr_q <= cap_vec;
      else if (sel && state == SH_DR) sr_q <= {tdi, sr_q[LEN-1:1]};
   end

   always_ff @(negedge tck) begin
      if (sel && state == UPD_DR) upd_q <= sr_q[LEN-1:UPD_LO];
   end

   assign bsr_tdo = sr_q[0];
   assign upd     = upd_q;

   // R7: every cell takes its pin value during Capture-DR
   p_bsr_capture_r7: assert property (@(posedge tck) disable iff (!primed)
      (sel && state == CAP_DR) |=> (sr_q == $past(cap_vec)));
endmodule

// File: rtl/bsl_latch.sv
`timescale 1ns/1ps
module bsl_latch #(
   parameter int W = 9
) (
   input  logic [W-1:0] d,
   input  logic         le,
   output logic [W-1:0] q
);
   always_latch begin
      if (le) q <= d;
   end
endmodule

// File: rtl/bsl_top.sv
`timescale 1ns/1ps
module bsl_top
   import bsl_pkg::*;
#(
   parameter int BYTE_W = 9
) (
   input  logic              tck,
   input  logic              tms,
   input  logic              tdi,
   output logic              tdo,
   output logic              tdo_en,
   input  logic [BYTE_W-1:0] a_din,
   input  logic [BYTE_W-1:0] b_din,
   input  logic              a_le,
   input  logic              b_le,
   input  logic              a_oe_n,
   input  logic              b_oe_n,
   output logic [BYTE_W-1:0] a_dout,
   output logic              a_dout_en,
   output logic [BYTE_W-1:0] b_dout,
   output logic              b_dout_en
);
   localparam int NB      = 2;
   localparam int IN_LO   = 0;
   localparam int CTL_LO  = IN_LO + NB * BYTE_W;
   localparam int OUT_LO  = CTL_LO + 2 * NB;
   localparam int EN_LO   = OUT_LO + NB * BYTE_W;
   localparam int BSR_LEN = EN_LO + NB;

   generate
      if (BYTE_W < 1) begin : g_bad_width
         $error("bsl_top: BYTE_W must be at least 1");
      end
   endgenerate

   tap_state_t state;
   logic       primed;
   instr_t     instr;
   logic       ir_tdo, bsr_tdo;
   logic       byp_q = 1'b0;
   logic       tdo_q = 1'b0;
   logic       tdo_en_q = 1'b0;

   logic [BYTE_W-1:0]        din  [NB];
   logic [BYTE_W-1:0]        q    [NB];
   logic [BYTE_W-1:0]        dout [NB];
   logic [NB-1:0]            le, oe_n, den;
   logic [BSR_LEN-1:0]       cap;
   logic [BSR_LEN-1:OUT_LO]  upd;

   wire sel_bsr   = (instr == I_SAMPLE) || (instr == I_EXTEST);
   wire ext_drive = (instr == I_EXTEST) || (instr == I_CLAMP);
   wire force_z   = (instr == I_HIGHZ);
   wire normal    = (instr == I_BYPASS) || (instr == I_SAMPLE);

   assign din[0] = a_din;
   assign din[1] = b_din;
   assign le     = {b_le, a_le};
   assign oe_n   = {b_oe_n, a_oe_n};

   bsl_tap i_tap (.tck(tck), .tms(tms), .state(state), .primed(primed));

   bsl_ir i_ir (.tck(tck), .tdi(tdi), .primed(primed), .state(state),
                .ir_tdo(ir_tdo), .instr(instr));

   bsl_bsr #(.LEN(BSR_LEN), .UPD_LO(OUT_LO)) i_bsr (
      .tck(tck), .tdi(tdi), .primed(primed), .state(state), .sel(sel_bsr),
      .cap_vec(cap), .bsr_tdo(bsr_tdo), .upd(upd));

   for (genvar g = 0; g < NB; g++) begin : g_byte
      bsl_latch #(.W(BYTE_W)) i_lat (.d(din[g]), .le(le[g]), .q(q[g]));

      assign dout[g] = ext_drive ? upd[OUT_LO + g*BYTE_W +: BYTE_W] : q[g];
      assign den[g]  = force_z ? 1'b0 : (ext_drive ? upd[EN_LO + g] : !oe_n[g]);

      assign cap[IN_LO + g*BYTE_W +: BYTE_W]  = din[g];
      assign cap[CTL_LO + g]                  = le[g];
      assign cap[CTL_LO + NB + g]             = oe_n[g];
      assign cap[OUT_LO + g*BYTE_W +: BYTE_W] = dout[g];
      assign cap[EN_LO + g]                   = den[g];
   end

   always_ff @(posedge tck) begin
      if (state == CAP_DR)     byp_q <= 1'b0;
      else if (state == SH_DR) byp_q <= tdi;
   end

   always_ff @(negedge tck) begin
      tdo_q    <= (state == SH_IR) ? ir_tdo : (sel_bsr ? bsr_tdo : byp_q);
      tdo_en_q <= (state == SH_IR) || (state == SH_DR);
   end

   assign tdo       = tdo_q;
   assign tdo_en    = tdo_en_q;
   assign a_dout    = dout[0];
   assign b_dout    = dout[1];
   assign a_dout_en = den[0];
   assign b_dout_en = den[1];

   // R1: open latch passes data straight to the pins
   p_transparent_r1: assert property (@(posedge tck) disable iff (!primed)
      (normal && a_le) |-> (a_dout == a_din));
   // R2: closed latch keeps the pins still
   p_hold_r2: assert property (@(posedge tck) disable iff (!primed)
      (normal && $past(normal) && !a_le && $past(!a_le)) |-> $stable(a_dout));
   // R3: high output enable turns the byte's driver off
   p_oe_off_r3: assert property (@(posedge tck) disable iff (!primed)
      (normal && b_oe_n) |-> !b_dout_en);
   // R11: HIGHZ turns every driver off
   p_highz_r11: assert property (@(posedge tck) disable iff (!primed)
      (instr == I_HIGHZ) |-> (!a_dout_en && !b_dout_en));
   // R12: TDO driven only in shift states
   p_tdo_en_r12: assert property (@(posedge tck) disable iff (!primed)
      tdo_en |-> (state == SH_DR || state == SH_IR));
endmodule

// File: tb/test_bsl_top.sv
`timescale 1ns/1ps
module test_bsl_top;
   logic       tck = 1'b0;
   logic       tms = 1'b1;
   logic       tdi = 1'b0;
   logic       tdo, tdo_en;
   logic [8:0] a_din = 9'h1A5, b_din = 9'h0C3;
   logic       a_le = 1'b1, b_le = 1'b1, a_oe_n = 1'b0, b_oe_n = 1'b0;
   logic [8:0] a_dout, b_dout;
   logic       a_dout_en, b_dout_en;
   int         n_chk = 0;
   int         n_fail = 0;

   always #4 tck = ~tck;

   bsl_top i_bsl_top (
      .tck(tck), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_en(tdo_en),
      .a_din(a_din), .b_din(b_din), .a_le(a_le), .b_le(b_le),
      .a_oe_n(a_oe_n), .b_oe_n(b_oe_n),
      .a_dout(a_dout), .a_dout_en(a_dout_en),
      .b_dout(b_dout), .b_dout_en(b_dout_en));

   task automatic chk(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic tick(input logic m, input logic d, output logic o, output logic e);
      tms = m;
      tdi = d;
      o = tdo;
      e = tdo_en;
      @(posedge tck);
      @(negedge tck);
      #1;
   endtask

   task automatic step(input logic m);
      logic o, e;
      tick(m, 1'b0, o, e);
   endtask

   task automatic tap_reset();
      for (int i = 0; i < 5; i++) step(1'b1);
      step(1'b0);
   endtask

   task automatic shift_ir(input logic [2:0] op, output logic [2:0] got, output logic en_ok);
      logic o, e;
      step(1'b1); step(1'b1); step(1'b0); step(1'b0);
      en_ok = 1'b1;
      for (int i = 0; i < 3; i++) begin
         tick(i == 2, op[i], o, e);
         got[i] = o;
         if (!e) en_ok = 1'b0;
      end
      step(1'b1); step(1'b0);
   endtask

   task automatic shift_dr(input int n, input logic [63:0] din, output logic [63:0] got,
                           output logic en_ok);
      logic o, e;
      got = '0;
      step(1'b1); step(1'b0); step(1'b0);
      en_ok = 1'b1;
      for (int i = 0; i < n; i++) begin
         tick(i == n - 1, din[i], o, e);
         got[i] = o;
         if (!e) en_ok = 1'b0;
      end
      step(1'b1); step(1'b0);
   endtask

   function automatic logic [63:0] cells(input logic [8:0] ai, input logic [8:0] bi,
         input logic al, input logic bl, input logic ao, input logic bo,
         input logic [8:0] ax, input logic [8:0] bx, input logic ae, input logic be);
      logic [63:0] v = '0;
      v[8:0] = ai;   v[17:9] = bi;
      v[18] = al;    v[19] = bl;   v[20] = ao;  v[21] = bo;
      v[30:22] = ax; v[39:31] = bx;
      v[40] = ae;    v[41] = be;
      return v;
   endfunction

   task automatic chk_bypass(input string req);
      logic [63:0] got;
      logic        ok;
      shift_dr(8, 64'hB5, got, ok);
      chk(req, "one-stage path", got[7:0], 8'h6A);
   endtask

   task automatic t_reset();
      chk("R4", "a_dout after TAP reset", a_dout, 9'h1A5);
      chk("R4", "a_dout_en after TAP reset", a_dout_en, 1'b1);
      chk("R1", "b_dout after TAP reset", b_dout, 9'h0C3);
      chk("R12", "tdo_en idle", tdo_en, 1'b0);
   endtask

   task automatic t_latch();
      a_din = 9'h05A; #8;
      chk("R1", "a follows", a_dout, 9'h05A);
      a_le = 1'b0; #8;
      a_din = 9'h1FF; #8;
      chk("R2", "a holds", a_dout, 9'h05A);
      b_din = 9'h111; #8;
      chk("R1", "b independent", b_dout, 9'h111);
      a_oe_n = 1'b1; #8;
      chk("R3", "a off", a_dout_en, 1'b0);
      chk("R3", "b still on", b_dout_en, 1'b1);
      a_oe_n = 1'b0; #8;
      chk("R2", "hold across oe toggle", a_dout, 9'h05A);
      a_le = 1'b1; #8;
      chk("R1", "a reopens", a_dout, 9'h1FF);
      a_oe_n = 1'b1; a_din = 9'h002; #8;
      chk("R3", "off while transparent", a_dout_en, 1'b0);
      a_oe_n = 1'b0; #8;
      @(negedge tck); #1;
   endtask

   task automatic t_ir_capture();
      logic [2:0] got;
      logic       ok;
      shift_ir(3'b001, got, ok);
      chk("R5", "IR capture pattern", got, 3'b001);
      chk("R12", "tdo_en in Shift-IR", ok, 1'b1);
      chk("R12", "tdo_en after shift", tdo_en, 1'b0);
   endtask

   task automatic t_sample();
      logic [63:0] got;
      logic        ok;
      a_din = 9'h155; b_din = 9'h0AA; b_oe_n = 1'b1;
      @(negedge tck); #1;
      shift_dr(42, cells(0, 0, 0, 0, 0, 0, 9'h0F0, 9'h10F, 1, 1), got, ok);
      chk("R7", "boundary capture", got,
          cells(9'h155, 9'h0AA, 1, 1, 0, 1, 9'h155, 9'h0AA, 1, 0));
      chk("R12", "tdo_en in Shift-DR", ok, 1'b1);
      chk("R8", "a_dout untouched", a_dout, 9'h155);
      chk("R8", "b_dout_en untouched", b_dout_en, 1'b0);
   endtask

   task automatic t_extest();
      logic [63:0] got;
      logic [2:0]  g3;
      logic        ok;
      shift_ir(3'b000, g3, ok);
      chk("R9", "a_dout preloaded", a_dout, 9'h0F0);
      chk("R9", "b_dout preloaded", b_dout, 9'h10F);
      chk("R9", "b_dout_en preloaded", b_dout_en, 1'b1);
      a_din = 9'h033; #8;
      chk("R9", "a_din blocked", a_dout, 9'h0F0);
      @(negedge tck); #1;
      shift_dr(42, cells(0, 0, 0, 0, 0, 0, 9'h1C7, 9'h038, 0, 1), got, ok);
      chk("R9", "capture of driven pins", got,
          cells(9'h033, 9'h0AA, 1, 1, 0, 1, 9'h0F0, 9'h10F, 1, 1));
      chk("R9", "a_dout updated", a_dout, 9'h1C7);
      chk("R9", "a_dout_en updated", a_dout_en, 1'b0);
      chk("R9", "b_dout updated", b_dout, 9'h038);
   endtask

   task automatic t_clamp();
      logic [2:0] g3;
      logic       ok;
      shift_ir(3'b010, g3, ok);
      chk("R10", "clamped a_dout", a_dout, 9'h1C7);
      chk("R10", "clamped b_dout_en", b_dout_en, 1'b1);
      chk_bypass("R10");
      chk("R10", "clamp unchanged by scan", a_dout, 9'h1C7);
   endtask

   task automatic t_highz();
      logic [2:0] g3;
      logic       ok;
      b_oe_n = 1'b0;
      @(negedge tck); #1;
      shift_ir(3'b011, g3, ok);
      chk("R11", "a_dout_en off", a_dout_en, 1'b0);
      chk("R11", "b_dout_en off", b_dout_en, 1'b0);
      chk_bypass("R11");
   endtask

   task automatic t_unused();
      logic [2:0] g3;
      logic       ok;
      shift_ir(3'b101, g3, ok);
      chk("R5", "unused code gives normal a_dout", a_dout, 9'h033);
      chk("R5", "unused code gives normal a_dout_en", a_dout_en, 1'b1);
      chk_bypass("R5");
      chk_bypass("R6");
   endtask

   task automatic t_tms_reset();
      logic [2:0] g3;
      logic       ok;
      shift_ir(3'b000, g3, ok);
      chk("R4", "EXTEST in force", a_dout, 9'h1C7);
      step(1'b1); step(1'b0); step(1'b0);
      for (int i = 0; i < 5; i++) step(1'b1);
      chk("R4", "a_dout back to latch", a_dout, 9'h033);
      chk("R4", "a_dout_en back to latch", a_dout_en, 1'b1);
      step(1'b0);
      chk_bypass("R4");
   endtask

   initial begin
      @(negedge tck); #1;
      tap_reset();
      t_reset();
      t_latch();
      t_ir_capture();
      tap_reset();
      chk_bypass("R6");
      t_ir_capture();
      t_sample();
      t_extest();
      t_clamp();
      t_highz();
      t_unused();
      t_tms_reset();
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      #800000;
      n_fail++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule